// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block performs integer multiplication and division for a 32-bit processor core. Results go into a private 64-bit accumulator made of two halves, HI (upper) and LO (lower). A request carries an operation code, two 32-bit operands and a destination register index. The block takes the request on any clock edge where it is not busy.

Multiplies, multiply-accumulates and moves into HI or LO complete in the edge that accepts them. A regular divide runs a restoring shift-subtract loop, one quotient bit per cycle. Divides by zero and the single signed overflow case finish at once with fixed results.

A move-from request returns HI or LO on a register write port one cycle after it is accepted. No write is produced when the destination is register zero. The issuing stage must hold any request, including a move-from, while `busy` is high. The block takes it once the divide has finished.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, HI and LO are 0, `busy` is low and `rd_valid` is low.
- R2: Operation 1 (signed multiply) and operation 2 (unsigned multiply) write the low half of the 64-bit product to LO and the high half to HI. Operation 1 sign-extends both operands; operation 2 zero-extends them.
- R3: Operations 3 and 5 (signed) and operations 4 and 6 (unsigned) treat {HI,LO} as one 64-bit value. Operations 3 and 4 add the 64-bit product of the operands; operations 5 and 6 subtract it. The 64-bit result is written back to HI and LO.
- R4: Operation 7 (signed divide) and operation 8 (unsigned divide) with a nonzero divisor put the quotient, truncated toward zero, in LO and the remainder in HI. In the signed case the remainder takes the sign of the dividend.
- R5: Operation 7 with dividend 0x80000000 and divisor 0xFFFFFFFF gives LO = 0x80000000 and HI = 0xFFFFFFFF.
- R6: Operation 7 with divisor 0 sets HI to the dividend. It sets LO to 1 if the dividend is negative, else to 0xFFFFFFFF.
- R7: Operation 8 with divisor 0 sets HI to the dividend. It sets LO to 0x0000FFFF if the dividend is at most 0xFFFF, else to 0xFFFFFFFF.
- R8: A divide covered by R4 holds `busy` high for exactly 32 cycles after its accepting edge and writes HI/LO on the edge where `busy` falls. Every other operation, including the cases of R5 to R7, leaves `busy` low.
- R9: A request presented while `busy` is high is not accepted and changes neither HI/LO nor the write port.
- R10: Operation 9 copies `opnd_a` into HI and operation 10 copies it into LO. Operation 11 reads HI and operation 12 reads LO. Either read drives `rd_valid` high for one cycle, one cycle after acceptance, with `rd_addr` equal to `req_dst` and `rd_data` equal to the register read.
- R11: A read (operation 11 or 12) with `req_dst` equal to 0 leaves `rd_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 4 | Operation code (see requirements) |
| opnd_a | input | 32 | First operand / dividend / move source |
| opnd_b | input | 32 | Second operand / divisor |
| req_dst | input | 5 | Destination register for reads of HI/LO |
| busy | output | 1 | Iterative divide in progress; requests are not taken |
| rd_valid | output | 1 | Register write strobe for a read of HI/LO |
| rd_addr | output | 5 | Register index of the write |
| rd_data | output | 32 | Value written |

## Verification
The hardest situation to reach is a request that arrives in the middle of a running divide. It must be refused without disturbing the accumulator the divide is about to overwrite.

The stimulus starts a long unsigned divide. It then holds a move-to-HI request on the inputs for several cycles while `busy` is high, and drops it before the divide ends. Reading HI and LO afterwards shows only the divide result.

The fixed-result divide cases sit next to the ordinary ones in the vector table. Each case is checked both for its HI/LO values and for whether `busy` ever rose.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  parameter int XLEN = 32;
  localparam int DLEN = 2 * XLEN;

  typedef logic [XLEN-1:0] word_t;
  typedef logic [DLEN-1:0] dword_t;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_MULS  = 4'd1,
    OP_MULU  = 4'd2,
    OP_MADDS = 4'd3,
    OP_MADDU = 4'd4,
    OP_MSUBS = 4'd5,
    OP_MSUBU = 4'd6,
    OP_DIVS  = 4'd7,
    OP_DIVU  = 4'd8,
    OP_MTHI  = 4'd9,
    OP_MTLO  = 4'd10,
    OP_MFHI  = 4'd11,
    OP_MFLO  = 4'd12
  } mdop_e;

  // Extend a word to double width, by sign or by zero.
  function automatic dword_t widen(input word_t x, input logic sgn);
    return {{XLEN{sgn & x[XLEN-1]}}, x};
  endfunction

  // Full double-width product; the low DLEN bits are exact for both forms.
  function automatic dword_t prod_full(input word_t a, input word_t b, input logic sgn);
    dword_t wa;
    dword_t wb;
    wa = widen(a, sgn);
    wb = widen(b, sgn);
    return wa * wb;
  endfunction

  // Magnitude of a word, read as signed when sgn is set.
  function automatic word_t mag_of(input word_t x, input logic sgn);
    return (sgn && x[XLEN-1]) ? (~x + word_t'(1)) : x;
  endfunction

  // Conditional two's-complement negation.
  function automatic word_t neg_if(input word_t x, input logic n);
    return n ? (~x + word_t'(1)) : x;
  endfunction
endpackage

// File: rtl/mul_path.sv
module mul_path
  import muldiv_pkg::*;
(
  input  mdop_e  op,
  input  word_t  a,
  input  word_t  b,
  input  dword_t acc_in,
  output dword_t acc_out,
  output logic   is_mul
);
  dword_t p_s;
  dword_t p_u;

  assign p_s = prod_full(a, b, 1'b1);
  assign p_u = prod_full(a, b, 1'b0);

  always_comb begin
    is_mul  = 1'b1;
    acc_out = acc_in;
    case (op)
      OP_MULS:  acc_out = p_s;
      OP_MULU:  acc_out = p_u;
      OP_MADDS: acc_out = acc_in + p_s;
      OP_MADDU: acc_out = acc_in + p_u;
      OP_MSUBS: acc_out = acc_in - p_s;
      OP_MSUBU: acc_out = acc_in - p_u;
      default:  is_mul  = 1'b0;
    endcase
  end
endmodule

// File: rtl/div_special.sv
module div_special
  import muldiv_pkg::*;
(
  input  word_t a,
  input  word_t b,
  input  logic  sgn,
  output logic  hit,
  output word_t hi_val,
  output word_t lo_val
);
  localparam word_t ALL1     = '1;
  localparam word_t MIN_NEG  = {1'b1, {(XLEN-1){1'b0}}};
  localparam word_t HALF_MAX = {{(XLEN/2){1'b0}}, {(XLEN/2){1'b1}}};

  logic zero_div;
  logic ovf;

  assign zero_div = (b == '0);
  assign ovf      = sgn && (a == MIN_NEG) && (b == ALL1);
  assign hit      = zero_div || ovf;

  always_comb begin
    if (ovf) begin
      hi_val = ALL1;
      lo_val = MIN_NEG;
    end else if (sgn) begin
      hi_val = a;
      lo_val = a[XLEN-1] ? word_t'(1) : ALL1;
    end else begin
      hi_val = a;
      lo_val = (a <= HALF_MAX) ? HALF_MAX : ALL1;
    end
  end
endmodule

// File: rtl/div_core.sv
module div_core
  import muldiv_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dvd_mag,
  input  logic [W-1:0] dvs_mag,
  input  logic         neg_q,
  input  logic         neg_r,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W);

  logic         active;
  logic [CW-1:0] cnt;
  logic [W-1:0] rem_q;
  logic [W-1:0] quo_q;
  logic [W-1:0] dvs_q;
  logic         nq_q;
  logic         nr_q;

  logic [W:0]   shifted;
  logic [W:0]   diff;
  logic         fits;
  logic [W-1:0] r_nxt;
  logic [W-1:0] q_nxt;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, dvs_q};
  assign fits    = ~diff[W];
  assign r_nxt   = fits ? diff[W-1:0] : shifted[W-1:0];
  assign q_nxt   = {quo_q[W-2:0], fits};

  assign busy_o = active;
  assign done_o = active && (cnt == CW'(W-1));
  assign quo_o  = nq_q ? (~q_nxt + 1'b1) : q_nxt;
  assign rem_o  = nr_q ? (~r_nxt + 1'b1) : r_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      nq_q   <= 1'b0;
      nr_q   <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      rem_q  <= '0;
      quo_q  <= dvd_mag;
      dvs_q  <= dvs_mag;
      nq_q   <= neg_q;
      nr_q   <= neg_r;
    end else if (active) begin
      rem_q <= r_nxt;
      quo_q <= q_nxt;
      cnt   <= cnt + 1'b1;
      if (done_o) active <= 1'b0;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic [RIDX_W-1:0] req_dst,
  output logic              busy,
  output logic              rd_valid,
  output logic [RIDX_W-1:0] rd_addr,
  output logic [XLEN-1:0]   rd_data
);
  mdop_e  op;
  word_t  hi_q;
  word_t  lo_q;
  dword_t hilo;
  dword_t mul_res;
  logic   is_mul;

  logic   accept;
  logic   is_div;
  logic   div_sgn;
  logic   is_mf;
  logic   spec_hit;
  word_t  spec_hi;
  word_t  spec_lo;

  // Named internal events, also observed by the checker
  logic   div_start;
  logic   spec_accept;
  logic   mf_accept;
  logic   div_done;

  word_t  div_quo;
  word_t  div_rem;

  logic   rd_valid_q;
  logic [RIDX_W-1:0] rd_addr_q;
  word_t  rd_data_q;

  assign op      = mdop_e'(req_op);
  assign hilo    = {hi_q, lo_q};
  assign accept  = req_valid && !busy;
  assign is_div  = (op == OP_DIVS) || (op == OP_DIVU);
  assign div_sgn = (op == OP_DIVS);
  assign is_mf   = (op == OP_MFHI) || (op == OP_MFLO);

  assign div_start   = accept && is_div && !spec_hit;
  assign spec_accept = accept && is_div && spec_hit;
  assign mf_accept   = accept && is_mf;

  mul_path u_mul (
    .op      (op),
    .a       (opnd_a),
    .b       (opnd_b),
    .acc_in  (hilo),
    .acc_out (mul_res),
    .is_mul  (is_mul)
  );

  div_special u_spec (
    .a      (opnd_a),
    .b      (opnd_b),
    .sgn    (div_sgn),
    .hit    (spec_hit),
    .hi_val (spec_hi),
    .lo_val (spec_lo)
  );

  div_core #(.W(XLEN)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (div_start),
    .dvd_mag (mag_of(opnd_a, div_sgn)),
    .dvs_mag (mag_of(opnd_b, div_sgn)),
    .neg_q   (div_sgn & (opnd_a[XLEN-1] ^ opnd_b[XLEN-1])),
    .neg_r   (div_sgn & opnd_a[XLEN-1]),
    .busy_o  (busy),
    .done_o  (div_done),
    .quo_o   (div_quo),
    .rem_o   (div_rem)
  );

  // Accumulator update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (div_done) begin
      hi_q <= div_rem;
      lo_q <= div_quo;
    end else if (accept) begin
      if (is_mul) begin
        hi_q <= mul_res[DLEN-1:XLEN];
        lo_q <= mul_res[XLEN-1:0];
      end else if (spec_accept) begin
        hi_q <= spec_hi;
        lo_q <= spec_lo;
      end else if (op == OP_MTHI) begin
        hi_q <= opnd_a;
      end else if (op == OP_MTLO) begin
        lo_q <= opnd_a;
      end
    end
  end

  // Register write port for reads of HI/LO
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_addr_q  <= '0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= mf_accept && (req_dst != '0);
      if (mf_accept) begin
        rd_addr_q <= req_dst;
        rd_data_q <= (op == OP_MFHI) ? hi_q : lo_q;
      end
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_addr  = rd_addr_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk
  import muldiv_pkg::*;
#(
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rd_valid,
  input logic [RIDX_W-1:0] rd_addr,
  input logic              div_start,
  input logic              div_done,
  input logic              spec_accept,
  input logic              mf_accept,
  input dword_t            hilo
);
  // R8
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |=> busy);

  // R8
  special_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spec_accept |=> !busy);

  // R9
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !div_done) |=> $stable(hilo));

  // R9
  no_read_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_valid);

  // R10
  read_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mf_accept));

  // R11
  zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr != '0));
endmodule

bind muldiv_unit muldiv_unit_chk #(.RIDX_W(RIDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .rd_valid    (rd_valid),
  .rd_addr     (rd_addr),
  .div_start   (div_start),
  .div_done    (div_done),
  .spec_accept (spec_accept),
  .mf_accept   (mf_accept),
  .hilo        (hilo)
);

// File: tb/muldiv_unit_tb_top.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = 4'd0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [4:0]  req_dst = '0;
  logic        busy;
  logic        rd_valid;
  logic [4:0]  rd_addr;
  logic [31:0] rd_data;

  int tests = 0;
  int fails = 0;

  logic        got_v;
  logic [4:0]  got_addr;
  logic [31:0] got_data;
  int          got_busy;

  always #2.5 clk = ~clk;

  muldiv_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .req_dst(req_dst),
    .busy(busy), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] ihi;
    logic [31:0] ilo;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 32'hFFFFFFFE, 32'd3,        32'h0, 32'h0,        8'd2}, // R2 signed
    '{4'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0,        8'd2}, // R2 unsigned
    '{4'd1, 32'h80000000, 32'h80000000, 32'h5, 32'h5,        8'd2}, // R2
    '{4'd3, 32'hFFFFFFFF, 32'd1,        32'h0, 32'hFFFFFFFF, 8'd3}, // R3 madd signed
    '{4'd4, 32'h00010000, 32'h00010000, 32'h1, 32'hFFFFFFFF, 8'd3}, // R3 madd unsigned
    '{4'd5, 32'd2,        32'd3,        32'h0, 32'd5,        8'd3}, // R3 msub signed
    '{4'd6, 32'd1,        32'd1,        32'h0, 32'h0,        8'd3}, // R3 msub unsigned
    '{4'd7, 32'hFFFFFFF9, 32'd2,        32'h0, 32'h0,        8'd4}, // R4 -7/2
    '{4'd7, 32'd7,        32'hFFFFFFFE, 32'h0, 32'h0,        8'd4}, // R4 7/-2
    '{4'd8, 32'd100,      32'd7,        32'h0, 32'h0,        8'd4}, // R4
    '{4'd8, 32'hFFFFFFFF, 32'd1,        32'h0, 32'h0,        8'd4}, // R4
    '{4'd7, 32'h80000000, 32'hFFFFFFFF, 32'h0, 32'h0,        8'd5}, // R5
    '{4'd7, 32'hFFFFFFFB, 32'd0,        32'h0, 32'h0,        8'd6}, // R6 negative
    '{4'd7, 32'd5,        32'd0,        32'h0, 32'h0,        8'd6}, // R6 positive
    '{4'd8, 32'h0000FFFF, 32'd0,        32'h0, 32'h0,        8'd7}, // R7 small
    '{4'd8, 32'h00010000, 32'd0,        32'h0, 32'h0,        8'd7}  // R7 large
  };

  // Reference model written from the requirements
  function automatic logic [63:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] hi,
                                        input logic [31:0] lo);
    longint ps;
    logic [63:0] pu;
    logic [63:0] acc;
    int sa;
    int sb;
    int q;
    int r;
    acc = {hi, lo};
    ps  = longint'($signed(a)) * longint'($signed(b));
    pu  = {32'd0, a} * {32'd0, b};
    sa  = a;
    sb  = b;
    case (op)
      4'd1: return 64'(ps);
      4'd2: return pu;
      4'd3: return acc + 64'(ps);
      4'd4: return acc + pu;
      4'd5: return acc - 64'(ps);
      4'd6: return acc - pu;
      4'd7: begin
        if (b == 0) return {a, (sa < 0) ? 32'd1 : 32'hFFFFFFFF};
        if (a == 32'h80000000 && b == 32'hFFFFFFFF) return {32'hFFFFFFFF, 32'h80000000};
        q = sa / sb;
        r = sa % sb;
        return {32'(r), 32'(q)};
      end
      4'd8: begin
        if (b == 0) return {a, (a <= 32'hFFFF) ? 32'h0000FFFF : 32'hFFFFFFFF};
        return {a % b, a / b};
      end
      default: return acc;
    endcase
  endfunction

  task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Issue one request; capture write port one cycle later and count busy cycles
  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] dst);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    opnd_a    = a;
    opnd_b    = b;
    req_dst   = dst;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got_v    = rd_valid;
    got_addr = rd_addr;
    got_data = rd_data;
    got_busy = 0;
    while (busy) begin
      got_busy++;
      @(negedge clk);
    end
  endtask

  task automatic read_hilo(output logic [31:0] hi, output logic [31:0] lo);
    issue(4'd11, '0, '0, 5'd3);
    hi = got_data;
    issue(4'd12, '0, '0, 5'd4);
    lo = got_data;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] h;
    logic [31:0] l;
    logic [63:0] e;
    int exp_busy;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(1, {63'd0, busy}, 64'd0, "busy in reset");
    check(1, {63'd0, rd_valid}, 64'd0, "rd_valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(1, {63'd0, busy}, 64'd0, "busy after reset");
    read_hilo(h, l);
    check(1, {h, l}, 64'd0, "HI:LO after reset");

    // Vector table: preload HI/LO, run op, read back
    for (int i = 0; i < NV; i++) begin
      issue(4'd9, VEC[i].ihi, '0, 5'd0);
      issue(4'd10, VEC[i].ilo, '0, 5'd0);
      issue(VEC[i].op, VEC[i].a, VEC[i].b, 5'd0);
      exp_busy = ((VEC[i].op == 4'd7 || VEC[i].op == 4'd8) && VEC[i].b != 0 &&
                  !(VEC[i].op == 4'd7 && VEC[i].a == 32'h80000000 && VEC[i].b == 32'hFFFFFFFF))
                 ? 32 : 0;
      check(8, 64'(got_busy), 64'(exp_busy), $sformatf("busy cycles vec %0d", i)); // R8
      read_hilo(h, l);
      e = model(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].ihi, VEC[i].ilo);
      check(int'(VEC[i].req), {32'd0, h}, {32'd0, e[63:32]}, $sformatf("HI vec %0d", i));
      check(int'(VEC[i].req), {32'd0, l}, {32'd0, e[31:0]}, $sformatf("LO vec %0d", i));
    end

    // R10 move to/from with write port fields
    issue(4'd9, 32'hCAFEF00D, 32'h1, 5'd0);
    issue(4'd10, 32'h0BADBEEF, 32'h2, 5'd0);
    issue(4'd11, 32'h0, 32'h0, 5'd7);
    check(10, {63'd0, got_v}, 64'd1, "rd_valid on MFHI");
    check(10, {59'd0, got_addr}, 64'd7, "rd_addr on MFHI");
    check(10, {32'd0, got_data}, 64'hCAFEF00D, "rd_data on MFHI");
    @(negedge clk);
    check(10, {63'd0, rd_valid}, 64'd0, "rd_valid single cycle");
    issue(4'd12, 32'h0, 32'h0, 5'd31);
    check(10, {27'd0, got_addr, got_data}, {27'd0, 5'd31, 32'h0BADBEEF}, "MFLO fields");

    // R11 read to register zero produces no write
    issue(4'd11, 32'h0, 32'h0, 5'd0);
    check(11, {63'd0, got_v}, 64'd0, "rd_valid for dst 0");
    issue(4'd12, 32'h0, 32'h0, 5'd0);
    check(11, {63'd0, got_v}, 64'd0, "rd_valid for dst 0 LO");

    // R9 request held during a running divide is ignored
    @(negedge clk);
    req_valid = 1'b1; req_op = 4'd8; opnd_a = 32'd1000; opnd_b = 32'd7; req_dst = 5'd0;
    @(posedge clk);
    @(negedge clk);
    req_op = 4'd9; opnd_a = 32'h12345678; req_dst = 5'd9;
    repeat (5) @(negedge clk);
    check(9, {63'd0, rd_valid}, 64'd0, "write port during busy");
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    read_hilo(h, l);
    check(9, {h, l}, {32'd6, 32'd142}, "HI:LO after request during busy");

    finish_run();
  end
endmodule